// File: doc/BRIEF.md
# ALU Status Flag Unit

This block holds the processor status word and computes the result of the integer arithmetic group: add, subtract, add with carry, subtract with borrow, negate, increment, and signed and unsigned multiply. It works on byte, word and long operands. An execution stage drives an operation code, a size code and two operands together with a valid strobe. The arithmetic result is available combinationally in the same cycle, and the zero, negative, carry, overflow, overflow-trap and sticky flags take their new values at the clock edge that accepts the operation.

The same unit also carries out the flag-only instructions. These set or clear carry, clear the overflow trap, and enable or disable interrupts. It accepts a whole status-word load as well, such as a flag pop. Any branch logic that tests the overflow trap can clear it through a dedicated input. Two behaviours matter for multi-word arithmetic. Zero is accumulated across carry and borrow chains. The overflow trap latches and stays set until an explicit clear.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset, every flag, the interrupt enable and the whole status word `psw_rd` read 0.
- R2: Operation codes: 0 add, 1 subtract, 2 add with carry, 3 subtract with borrow, 4 negate, 5 increment, 6 unsigned multiply, 7 signed multiply, 8 set carry, 9 clear carry, 10 clear trap, 11 interrupt enable, 12 interrupt disable, 13 status-word load. For add and subtract, `result` is the sum or difference modulo 2^W, zero-extended, and C is the carry out of the top bit of the size. After a subtract, C is 1 when no borrow occurred and 0 when one did.
- R3: V is set when the signed result does not fit the size. VT is set along with V and stays set through later operations that leave V at 0.
- R4: N is the true sign of the exact result (top result bit XOR V), so it stays correct when the operation overflows.
- R5: Add with carry and subtract with borrow use the current C as carry-in (borrow-in is NOT C). Their Z becomes old Z AND (result == 0), so these operations can clear Z but never set it.
- R6: Add, subtract, negate and increment set Z exactly when the sized result is 0.
- R7: Negate computes 0 − A and increment computes A + 1, with all flags as for the corresponding subtract or add.
- R8: The size code selects the width: 0 is byte (8), 1 is word (16), and 2 and 3 are long (32). Operand bits above the selected width have no effect.
- R9: A multiply returns the full 2W-bit product in `result`, with the bits above it at 0. It leaves Z, N, C, V, VT and the interrupt enable unchanged, and it clears ST.
- R10: Set carry and clear carry force C. Clear trap clears VT. Interrupt enable and disable set and clear `int_en`, which is status-word bit 9.
- R11: A high `vt_clr_jmp` clears VT at the next edge. This takes priority over an overflow that sets VT in the same cycle.
- R12: The status-word layout is I=9, Z=7, N=6, V=5, VT=4, C=3, X=2, ST=0, and all other bits read 0. A load (code 13) takes these fields from `opnd_a[15:0]`, and bit X is always stored as 0.
- R13: With `op_valid` low, or with codes 14 and 15, the flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operation at this edge |
| op_code | input | 4 | Operation select |
| op_size | input | 2 | Operand size select |
| opnd_a | input | 32 | First operand, or word to load into the status word |
| opnd_b | input | 32 | Second operand |
| vt_clr_jmp | input | 1 | Clear the overflow trap (from trap-testing branch) |
| result | output | 64 | Arithmetic or product result |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_c | output | 1 | Carry / not-borrow |
| flag_v | output | 1 | Overflow |
| flag_vt | output | 1 | Overflow trap |
| flag_st | output | 1 | Sticky |
| int_en | output | 1 | Global interrupt enable |
| psw_rd | output | 16 | Packed status word |

## Verification
The bench runs a two-word add-with-carry chain in which the upper half of the sum is zero but the lower half is not. A design that recomputes Z instead of accumulating it would report zero for that chain. Signed overflow is driven at the byte boundary (0x7F+1), at the word boundary (0x8000−1) and by negating 0x80. A design that takes N straight from the result's top bit would report the wrong sign in those cases, and one that loses the trap latch would drop VT on the next clean add. The bench also sets up an overflow and a branch trap-clear in the same cycle, and a design that gave the overflow priority would leave VT set. Finally it checks signed against unsigned byte products, operand bits above the selected size, and a status-word load of all ones. These would catch sign-extension errors in the multiplier, masking faults, and a stored X bit.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   localparam int PSW_W = 16;

   localparam logic [3:0] OP_ADD   = 4'd0;
   localparam logic [3:0] OP_SUB   = 4'd1;
   localparam logic [3:0] OP_ADDC  = 4'd2;
   localparam logic [3:0] OP_SUBB  = 4'd3;
   localparam logic [3:0] OP_NEG   = 4'd4;
   localparam logic [3:0] OP_INC   = 4'd5;
   localparam logic [3:0] OP_MULU  = 4'd6;
   localparam logic [3:0] OP_MULS  = 4'd7;
   localparam logic [3:0] OP_SETC  = 4'd8;
   localparam logic [3:0] OP_CLRC  = 4'd9;
   localparam logic [3:0] OP_CLRVT = 4'd10;
   localparam logic [3:0] OP_EI    = 4'd11;
   localparam logic [3:0] OP_DI    = 4'd12;
   localparam logic [3:0] OP_PSWLD = 4'd13;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_LALT = 2'd3
   } size_e;

   localparam int PSW_I_BIT  = 9;
   localparam int PSW_Z_BIT  = 7;
   localparam int PSW_N_BIT  = 6;
   localparam int PSW_V_BIT  = 5;
   localparam int PSW_VT_BIT = 4;
   localparam int PSW_C_BIT  = 3;
   localparam int PSW_X_BIT  = 2;
   localparam int PSW_ST_BIT = 0;

   typedef struct packed {
      logic ien;
      logic z;
      logic n;
      logic v;
      logic vt;
      logic c;
      logic st;
   } flags_t;

endpackage

// File: rtl/alu_flag_addsub.sv
// Adder on left-aligned operands: the selected size sits in the upper bits,
// so carry and overflow always come from the same physical bit.
module alu_flag_addsub #(
   parameter int LONG_W = 32
) (
   input  logic [LONG_W-1:0] a_al,
   input  logic [LONG_W-1:0] b_al,
   input  logic [LONG_W-1:0] cin_al,
   output logic [LONG_W-1:0] sum_al,
   output logic              cout,
   output logic              ovf
);
   localparam int MSB = LONG_W - 1;

   logic [LONG_W:0] full;

   always_comb begin
      full   = {1'b0, a_al} + {1'b0, b_al} + {1'b0, cin_al};
      sum_al = full[MSB:0];
      cout   = full[LONG_W];
      ovf    = (a_al[MSB] == b_al[MSB]) && (full[MSB] != a_al[MSB]);
   end
endmodule

// File: rtl/alu_flag_mul.sv
module alu_flag_mul import alu_flag_pkg::*; #(
   parameter int BYTE_W = 8,
   parameter int LONG_W = 4 * BYTE_W,
   parameter int RES_W  = 2 * LONG_W
) (
   input  logic [LONG_W-1:0] a,
   input  logic [LONG_W-1:0] b,
   input  size_e             sz,
   input  logic              sgn,
   output logic [RES_W-1:0]  prod
);
   localparam int WORD_W = 2 * BYTE_W;

   function automatic logic [RES_W-1:0] ext(input logic [LONG_W-1:0] x,
                                            input size_e s, input logic sg);
      logic [RES_W-1:0] r;
      case (s)
         SZ_BYTE: r = {{(RES_W-BYTE_W){sg & x[BYTE_W-1]}}, x[BYTE_W-1:0]};
         SZ_WORD: r = {{(RES_W-WORD_W){sg & x[WORD_W-1]}}, x[WORD_W-1:0]};
         default: r = {{(RES_W-LONG_W){sg & x[LONG_W-1]}}, x};
      endcase
      return r;
   endfunction

   logic [RES_W-1:0] full;

   always_comb begin
      full = ext(a, sz, sgn) * ext(b, sz, sgn);
      case (sz)
         SZ_BYTE: prod = {{(RES_W-2*BYTE_W){1'b0}}, full[2*BYTE_W-1:0]};
         SZ_WORD: prod = {{(RES_W-2*WORD_W){1'b0}}, full[2*WORD_W-1:0]};
         default: prod = full;
      endcase
   end
endmodule

// File: rtl/alu_flag_psw.sv
module alu_flag_psw import alu_flag_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op,
   input  logic             res_zero,
   input  logic             res_n,
   input  logic             res_c,
   input  logic             res_v,
   input  logic             vt_clr,
   input  logic [PSW_W-1:0] wr_word,
   output flags_t           flags,
   output logic [PSW_W-1:0] psw_word
);
   flags_t nxt;
   logic   wr_unused;

   assign wr_unused = ^{wr_word[15:10], wr_word[8], wr_word[PSW_X_BIT], wr_word[1]};

   always_comb begin
      nxt = flags;
      if (op_valid) begin
         case (op)
            OP_ADD, OP_SUB, OP_NEG, OP_INC, OP_ADDC, OP_SUBB: begin
               nxt.z  = (op == OP_ADDC || op == OP_SUBB) ? (flags.z & res_zero) : res_zero;
               nxt.n  = res_n;
               nxt.c  = res_c;
               nxt.v  = res_v;
               nxt.vt = flags.vt | res_v;
            end
            OP_MULU, OP_MULS: nxt.st = 1'b0;
            OP_SETC:  nxt.c   = 1'b1;
            OP_CLRC:  nxt.c   = 1'b0;
            OP_CLRVT: nxt.vt  = 1'b0;
            OP_EI:    nxt.ien = 1'b1;
            OP_DI:    nxt.ien = 1'b0;
            OP_PSWLD: begin
               nxt.ien = wr_word[PSW_I_BIT];
               nxt.z   = wr_word[PSW_Z_BIT];
               nxt.n   = wr_word[PSW_N_BIT];
               nxt.v   = wr_word[PSW_V_BIT];
               nxt.vt  = wr_word[PSW_VT_BIT];
               nxt.c   = wr_word[PSW_C_BIT];
               nxt.st  = wr_word[PSW_ST_BIT];
            end
            default: nxt = flags;
         endcase
      end
      if (vt_clr) nxt.vt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= nxt;
   end

   always_comb begin
      psw_word             = '0;
      psw_word[PSW_I_BIT]  = flags.ien;
      psw_word[PSW_Z_BIT]  = flags.z;
      psw_word[PSW_N_BIT]  = flags.n;
      psw_word[PSW_V_BIT]  = flags.v;
      psw_word[PSW_VT_BIT] = flags.vt;
      psw_word[PSW_C_BIT]  = flags.c;
      psw_word[PSW_ST_BIT] = flags.st;
   end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit import alu_flag_pkg::*; #(
   parameter  int BYTE_W = 8,
   localparam int LONG_W = 4 * BYTE_W,
   localparam int RES_W  = 2 * LONG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [1:0]        op_size,
   input  logic [LONG_W-1:0] opnd_a,
   input  logic [LONG_W-1:0] opnd_b,
   input  logic              vt_clr_jmp,
   output logic [RES_W-1:0]  result,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_c,
   output logic              flag_v,
   output logic              flag_vt,
   output logic              flag_st,
   output logic              int_en,
   output logic [PSW_W-1:0]  psw_rd
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam int LANES  = LONG_W / BYTE_W;

   if (BYTE_W < 4) begin : g_bad_byte
      $error("alu_flag_unit: BYTE_W must be at least 4");
   end
   if (LANES * BYTE_W != LONG_W) begin : g_bad_lanes
      $error("alu_flag_unit: long width must be whole bytes");
   end

   size_e  sz;
   flags_t flags;
   assign sz = size_e'(op_size);

   function automatic logic [LONG_W-1:0] align(input logic [LONG_W-1:0] x, input size_e s);
      logic [LONG_W-1:0] r;
      case (s)
         SZ_BYTE: r = {x[BYTE_W-1:0], {(LONG_W-BYTE_W){1'b0}}};
         SZ_WORD: r = {x[WORD_W-1:0], {(LONG_W-WORD_W){1'b0}}};
         default: r = x;
      endcase
      return r;
   endfunction

   // operand routing per operation
   logic [LONG_W-1:0] src_a, src_b;
   logic              cin;
   logic              is_arith, is_mul;

   always_comb begin
      src_a = opnd_a;
      src_b = opnd_b;
      cin   = 1'b0;
      case (op_code)
         OP_SUB:  begin src_b = ~opnd_b; cin = 1'b1;   end
         OP_ADDC: begin cin = flags.c;                 end
         OP_SUBB: begin src_b = ~opnd_b; cin = flags.c; end
         OP_NEG:  begin src_a = '0; src_b = ~opnd_a; cin = 1'b1; end
         OP_INC:  begin src_b = '0; cin = 1'b1;        end
         default: ;
      endcase
      is_arith = (op_code <= OP_INC);
      is_mul   = (op_code == OP_MULU) || (op_code == OP_MULS);
   end

   logic [LONG_W-1:0] sum_al;
   logic              cout, ovf;

   alu_flag_addsub #(.LONG_W(LONG_W)) u_add (
      .a_al   (align(src_a, sz)),
      .b_al   (align(src_b, sz)),
      .cin_al (align(LONG_W'(cin), sz)),
      .sum_al (sum_al),
      .cout   (cout),
      .ovf    (ovf)
   );

   // per-lane zero detect; lanes below the selected size are zero by alignment
   logic [LANES-1:0] lane_nz;
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_nz[g] = |sum_al[g*BYTE_W +: BYTE_W];
   end

   logic res_zero, res_n;
   assign res_zero = ~|lane_nz;
   assign res_n    = sum_al[LONG_W-1] ^ ovf;

   logic [LONG_W-1:0] sum_out;
   always_comb begin
      case (sz)
         SZ_BYTE: sum_out = LONG_W'(sum_al[LONG_W-1 -: BYTE_W]);
         SZ_WORD: sum_out = LONG_W'(sum_al[LONG_W-1 -: WORD_W]);
         default: sum_out = sum_al;
      endcase
   end

   logic [RES_W-1:0] prod;
   alu_flag_mul #(.BYTE_W(BYTE_W), .LONG_W(LONG_W), .RES_W(RES_W)) u_mul (
      .a    (opnd_a),
      .b    (opnd_b),
      .sz   (sz),
      .sgn  (op_code == OP_MULS),
      .prod (prod)
   );

   always_comb begin
      if (is_arith)    result = RES_W'(sum_out);
      else if (is_mul) result = prod;
      else             result = '0;
   end

   alu_flag_psw u_psw (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op       (op_code),
      .res_zero (res_zero),
      .res_n    (res_n),
      .res_c    (cout),
      .res_v    (ovf),
      .vt_clr   (vt_clr_jmp),
      .wr_word  (opnd_a[PSW_W-1:0]),
      .flags    (flags),
      .psw_word (psw_rd)
   );

   assign flag_z  = flags.z;
   assign flag_n  = flags.n;
   assign flag_c  = flags.c;
   assign flag_v  = flags.v;
   assign flag_vt = flags.vt;
   assign flag_st = flags.st;
   assign int_en  = flags.ien;
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk import alu_flag_pkg::*; (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [3:0]       op_code,
   input logic             vt_clr_jmp,
   input logic             flag_z,
   input logic             flag_v,
   input logic             flag_vt,
   input logic             int_en,
   input logic [PSW_W-1:0] psw_rd
);
   // R3
   v_sets_vt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code <= OP_INC && !vt_clr_jmp) |=> (!flag_v || flag_vt));

   // R3
   vt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_vt && !vt_clr_jmp && !(op_valid && (op_code == OP_CLRVT || op_code == OP_PSWLD)))
      |=> flag_vt);

   // R5
   chain_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_ADDC || op_code == OP_SUBB)) |=> !$rose(flag_z));

   // R9
   mul_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_MULU || op_code == OP_MULS) && !vt_clr_jmp)
      |=> $stable(psw_rd[PSW_W-1:1]));

   // R10
   ei_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_EI) |=> int_en);

   // R11
   jmp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vt_clr_jmp |=> !flag_vt);

   // R12
   x_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psw_rd[PSW_X_BIT] == 1'b0);

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !vt_clr_jmp) |=> $stable(psw_rd));
endmodule

bind alu_flag_unit alu_flag_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_code    (op_code),
   .vt_clr_jmp (vt_clr_jmp),
   .flag_z     (flag_z),
   .flag_v     (flag_v),
   .flag_vt    (flag_vt),
   .int_en     (int_en),
   .psw_rd     (psw_rd)
);

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic [1:0]  op_size = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        vt_clr_jmp = 1'b0;
   logic [63:0] result;
   logic        flag_z, flag_n, flag_c, flag_v, flag_vt, flag_st, int_en;
   logic [15:0] psw_rd;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   alu_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .vt_clr_jmp(vt_clr_jmp),
      .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
      .flag_v(flag_v), .flag_vt(flag_vt), .flag_st(flag_st), .int_en(int_en),
      .psw_rd(psw_rd)
   );

   // size codes and op codes as stated in R2 / R8
   localparam logic [1:0] B = 2'd0, W = 2'd1, L = 2'd2, L3 = 2'd3;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // status word layout per R12: I9 Z7 N6 V5 VT4 C3 ST0
   task automatic chk_psw(input string req, input logic [15:0 ] exp);
      chk(req, {48'd0, psw_rd}, {48'd0, exp});
      chk({req, " flag pins"},
          {57'd0, int_en, flag_z, flag_n, flag_v, flag_vt, flag_c, flag_st},
          {57'd0, exp[9], exp[7], exp[6], exp[5], exp[4], exp[3], exp[0]});
   endtask

   task automatic do_op(input string req, input logic [3:0] op, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] b, input bit jclr,
                        input bit chk_res, input logic [63:0] exp_res,
                        input logic [15:0] exp_psw);
      @(negedge clk);
      op_valid = 1'b1; op_code = op; op_size = sz;
      opnd_a = a; opnd_b = b; vt_clr_jmp = jclr;
      #1;
      if (chk_res) chk({req, " result"}, result, exp_res);
      @(posedge clk);
      #1;
      op_valid = 1'b0; vt_clr_jmp = 1'b0;
      chk_psw({req, " psw"}, exp_psw);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk_psw("R1 reset", 16'h0000);
   endtask

   task automatic t_add_sub;
      // byte overflow, upper operand bits junk (R8)
      do_op("R3 R4 R8 add byte ovf", 4'd0, B, 32'hFFFF_FF7F, 32'hABCD_EF01, 0, 1, 64'h80, 16'h0030);
      do_op("R2 R6 R3 add byte carry", 4'd0, B, 32'h1234_56FF, 32'h0000_0001, 0, 1, 64'h00, 16'h0098);
      do_op("R2 sub word borrow", 4'd1, W, 32'h0003, 32'h0005, 0, 1, 64'hFFFE, 16'h0050);
      do_op("R2 sub word no borrow", 4'd1, W, 32'h0005, 32'h0003, 0, 1, 64'h0002, 16'h0018);
      do_op("R4 sub word ovf", 4'd1, W, 32'h0000_8000, 32'h0000_0001, 0, 1, 64'h7FFF, 16'h0078);
   endtask

   task automatic t_chain;
      do_op("R5 add low", 4'd0, L, 32'hFFFF_FFFF, 32'h1, 0, 1, 64'h0, 16'h0098);
      do_op("R5 addc high nonzero", 4'd2, L, 32'h1, 32'h0, 0, 1, 64'h2, 16'h0010);
      do_op("R5 add low nonzero", 4'd0, L, 32'h1, 32'h1, 0, 1, 64'h2, 16'h0010);
      do_op("R5 addc zero keeps z", 4'd2, L, 32'h0, 32'h0, 0, 1, 64'h0, 16'h0010);
      do_op("R5 sub low borrow", 4'd1, L, 32'h0, 32'h1, 0, 1, 64'hFFFF_FFFF, 16'h0050);
      do_op("R5 subb uses borrow", 4'd3, L, 32'h5, 32'h4, 0, 1, 64'h0, 16'h0018);
      do_op("R5 sub low zero", 4'd1, L, 32'h5, 32'h5, 0, 1, 64'h0, 16'h0098);
      do_op("R5 subb zero keeps z", 4'd3, L, 32'h3, 32'h3, 0, 1, 64'h0, 16'h0098);
   endtask

   task automatic t_neg_inc;
      do_op("R7 R4 neg byte 80", 4'd4, B, 32'h80, 32'h0, 0, 1, 64'h80, 16'h0030);
      do_op("R7 R6 neg byte 0", 4'd4, B, 32'h0, 32'h0, 0, 1, 64'h00, 16'h0098);
      do_op("R7 inc word wrap", 4'd5, W, 32'hFFFF, 32'h0, 0, 1, 64'h0, 16'h0098);
      do_op("R7 inc word ovf", 4'd5, W, 32'h7FFF, 32'h0, 0, 1, 64'h8000, 16'h0030);
   endtask

   task automatic t_flag_ops;
      do_op("R10 clrvt", 4'd10, B, 32'h0, 32'h0, 0, 0, 64'h0, 16'h0020);
      do_op("R10 setc", 4'd8, B, 32'h0, 32'h0, 0, 0, 64'h0, 16'h0028);
      do_op("R10 clrc", 4'd9, B, 32'h0, 32'h0, 0, 0, 64'h0, 16'h0020);
      do_op("R10 ei", 4'd11, B, 32'h0, 32'h0, 0, 0, 64'h0, 16'h0220);
      do_op("R10 di", 4'd12, B, 32'h0, 32'h0, 0, 0, 64'h0, 16'h0020);
   endtask

   task automatic t_jmp_clear;
      do_op("R11 clear beats ovf", 4'd0, B, 32'h7F, 32'h1, 1, 1, 64'h80, 16'h0020);
      do_op("R3 clean add", 4'd0, B, 32'h1, 32'h1, 0, 1, 64'h2, 16'h0000);
      do_op("R3 ovf again", 4'd0, B, 32'h7F, 32'h1, 0, 1, 64'h80, 16'h0030);
      @(negedge clk);
      vt_clr_jmp = 1'b1; op_code = 4'd11;
      @(posedge clk);
      #1;
      vt_clr_jmp = 1'b0;
      chk_psw("R11 clear alone", 16'h0020);
   endtask

   task automatic t_mul;
      do_op("R12 load all ones", 4'd13, B, 32'h0000_FFFF, 32'h0, 0, 0, 64'h0, 16'h02F9);
      do_op("R9 mulu byte", 4'd6, B, 32'hFF, 32'hFF, 0, 1, 64'hFE01, 16'h02F8);
      do_op("R9 muls byte", 4'd7, B, 32'h1234_56FF, 32'hFF, 0, 1, 64'h0001, 16'h02F8);
      do_op("R9 muls word", 4'd7, W, 32'hFFFE, 32'h3, 0, 1, 64'hFFFF_FFFA, 16'h02F8);
      do_op("R9 mulu long", 4'd6, L, 32'hFFFF_FFFF, 32'h2, 0, 1, 64'h1_FFFF_FFFE, 16'h02F8);
      do_op("R9 R8 mulu size3", 4'd6, L3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1,
            64'hFFFF_FFFE_0000_0001, 16'h02F8);
   endtask

   task automatic t_psw_load;
      do_op("R12 load x only", 4'd13, B, 32'h0004, 32'h0, 0, 0, 64'h0, 16'h0000);
      do_op("R12 load i st", 4'd13, B, 32'hFFFF_0201, 32'h0, 0, 0, 64'h0, 16'h0201);
   endtask

   task automatic t_hold;
      do_op("R13 code 14", 4'd14, L, 32'hFFFF_FFFF, 32'h1, 0, 0, 64'h0, 16'h0201);
      do_op("R13 code 15", 4'd15, L, 32'h0, 32'h0, 0, 0, 64'h0, 16'h0201);
      @(negedge clk);
      op_valid = 1'b0; op_code = 4'd8; op_size = L; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1;
      @(posedge clk);
      #1;
      chk_psw("R13 valid low", 16'h0201);
      do_op("R8 add size3 long", 4'd0, L3, 32'hFFFF_FFFF, 32'h1, 0, 1, 64'h0, 16'h0289);
   endtask

   initial begin
      t_reset();
      t_add_sub();
      t_chain();
      t_neg_inc();
      t_flag_ops();
      t_jmp_clear();
      t_mul();
      t_psw_load();
      t_hold();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule